// File: doc/BRIEF.md
# SAR ADC Track and Convert Sequencer

This block runs the timing of a 10-bit successive-approximation converter. It counts SAR clocks, which arrive as a one-cycle enable on the system clock. It drives the track/hold switch and presents a trial code to the DAC. On each bit step it takes the comparator's decision and builds the result most significant bit first. When the conversion is finished it latches the result and raises a one-cycle done pulse.

A 3-bit selector chooses what starts a conversion: a software start pulse, one of three timer overflow pulses, or the rising edge of an external pin. The pin passes through a synchronizer first. An optional delayed mode keeps the input tracking for three SAR clocks after the start before the bit decisions begin. A short mode resolves 8 bits instead of 10. Both options are captured when the conversion starts.

Top module: `sar_seq`

## Requirements
- R1: The start source follows `src_sel`. 3'b000 selects `sw_go`, 3'b001 selects `tmr0_ovf`, 3'b010 selects `tmr2_ovf`, 3'b011 selects `tmr1_ovf`, and any value 3'b1xx selects the rising edge of `cnv_pin`. Pulses on unselected sources have no effect.
- R2: `cnv_pin` goes through a two-flop synchronizer and an edge detector. `busy` rises on the third clock edge after the pin goes high. Both synchronizer flops reset to 1, so a pin that is high during reset does not start a conversion.
- R3: A selected start while idle sets `busy` at the next clock edge. The final SAR clock of a conversion clears `busy` and sets `done` at the same edge. `done` is high for exactly one clock.
- R4: A start that arrives while `busy` is high is ignored and is not queued. After that conversion ends, `busy` stays low.
- R5: Counting the SAR clock enables taken while `busy` is high, `done` follows the last of them. The count is 14 for 10-bit immediate mode, 12 for 8-bit immediate mode, 17 for 10-bit delayed mode and 15 for 8-bit delayed mode.
- R6: When the start source is internal (`src_sel[2]`=0), `track` is 1 whenever `busy` is low. During a conversion, `track` is 1 for the first three SAR clocks in delayed mode and 0 for the rest of the conversion.
- R7: When the start source is the external pin and the block is idle, `track` is 1 if `delay_trk`=1. If `delay_trk`=0, `track` is the inverse of the synchronized pin: it is 1 while the pin is low.
- R8: Bit steps are numbered from 1 and start at SAR clock (pre+1), where pre is 3 in delayed mode and 0 in immediate mode. Step j asserts only `step_stb[10-j]`, in the cycle of that SAR clock enable. There are 10 steps in 10-bit mode and 8 steps (bits 9 down to 2) in 8-bit mode. `step_stb` is zero at all other times.
- R9: The trial code starts at 10'h200. At each step the bit is kept when `cmp_hi`=1 and cleared when `cmp_hi`=0, and the next lower bit is then set for trial. With a comparator of the form `cmp_hi` = (vin >= `dac_code`), the 10-bit result equals vin and the 8-bit result equals vin>>2, right-justified. `result` is loaded only at `done` and holds its value until the next `done`.
- R10: `delay_trk` and `res8` are sampled at the start. Changing them during a conversion does not change its length or its result width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sar_en | input | 1 | One-cycle SAR clock enable |
| src_sel | input | 3 | Start source select |
| delay_trk | input | 1 | Delayed tracking option |
| res8 | input | 1 | 8-bit result mode |
| sw_go | input | 1 | Software start pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| cnv_pin | input | 1 | External convert-start pin, asynchronous |
| cmp_hi | input | 1 | Comparator decision, 1 when input >= DAC code |
| track | output | 1 | Track/hold control, 1 = track |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 10 | Trial code for the DAC |
| step_stb | output | 10 | One-hot strobe of the bit being decided |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Latched conversion result |

## Verification
A wrong SAR clock count shows up quickly. Within the affected conversion, the step strobe lands on the wrong bit, `track` drops too early or too late, or `done` arrives on the wrong SAR clock. A corrupted trial code or decision shows only at `done`, as a `result` that differs from the input value. Faults in source selection, the busy gate or the synchronizer appear one to three clocks after the offending pulse, as `busy` going high when it should stay low, or staying low when it should rise.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W  = 10,
  parameter int SHORT_W = 8,
  parameter int PRE_N  = 3,
  parameter int TAIL_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sar_en,
  input  logic [2:0]       src_sel,
  input  logic             delay_trk,
  input  logic             res8,
  input  logic             sw_go,
  input  logic             tmr0_ovf,
  input  logic             tmr2_ovf,
  input  logic             tmr1_ovf,
  input  logic             cnv_pin,
  input  logic             cmp_hi,
  output logic             track,
  output logic             busy,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] step_stb,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int CW = $clog2(PRE_N + RES_W + TAIL_N + 1);
  localparam int IW = $clog2(RES_W);

  logic [2:0]       psync;
  logic             ext_rise, start;
  logic             dly_q, r8_q;
  logic [CW-1:0]    cnt, nxt, pre, nsteps, last, step_no;
  logic [IW-1:0]    idx;
  logic             in_step, fin;
  logic [RES_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psync <= 3'b111;
    else        psync <= {psync[1:0], cnv_pin};

  assign ext_rise = psync[1] & ~psync[2];

  always_comb begin
    case (src_sel)
      3'b000:  start = sw_go;
      3'b001:  start = tmr0_ovf;
      3'b010:  start = tmr2_ovf;
      3'b011:  start = tmr1_ovf;
      default: start = ext_rise;
    endcase
  end

  assign pre     = dly_q ? CW'(PRE_N) : '0;
  assign nsteps  = r8_q ? CW'(SHORT_W) : CW'(RES_W);
  assign last    = pre + nsteps + CW'(TAIL_N);
  assign nxt     = cnt + CW'(1);
  assign step_no = nxt - pre;
  assign in_step = busy & sar_en & (nxt > pre) & (step_no <= nsteps);
  assign idx     = IW'(RES_W - 1) - IW'(step_no - CW'(1));
  assign fin     = busy & sar_en & (nxt == last);
  assign step_stb = in_step ? (RES_W'(1) << idx) : '0;

  assign track = busy ? (cnt < pre) : (~src_sel[2] | delay_trk | ~psync[1]);
  assign dac_code = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      dly_q  <= 1'b0;
      r8_q   <= 1'b0;
      cnt    <= '0;
      code   <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          dly_q <= delay_trk;
          r8_q  <= res8;
          cnt   <= '0;
          code  <= RES_W'(1) << (RES_W - 1);
        end
      end else if (sar_en) begin
        cnt <= nxt;
        if (in_step) begin
          code[idx] <= cmp_hi;
          if (step_no < nsteps) code[idx - IW'(1)] <= 1'b1;
        end
        if (fin) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= r8_q ? (code >> (RES_W - SHORT_W)) : code;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(parameter int RES_W = 10) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       src_sel,
  input logic             track,
  input logic             busy,
  input logic [RES_W-1:0] step_stb,
  input logic             done,
  input logic [RES_W-1:0] result
);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  p_stb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_stb));
  p_stb_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb != '0) |-> (busy && !track));
  p_idle_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !src_sel[2]) |-> track);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .track(track), .busy(busy),
  .step_stb(step_stb), .done(done), .result(result)
);

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;
  logic clk = 0, rst_n = 0, sar_en = 0;
  logic [2:0] src_sel = 0;
  logic delay_trk = 0, res8 = 0, sw_go = 0, tmr0_ovf = 0, tmr2_ovf = 0, tmr1_ovf = 0;
  logic cnv_pin = 0;
  logic cmp_hi;
  logic track, busy, done;
  logic [9:0] dac_code, step_stb, result;
  logic [9:0] vin = 0;
  logic [3:0] go_next = 0;
  int total = 0, bad = 0, divc = 0;

  always #2 clk = ~clk;
  assign cmp_hi = (vin >= dac_code);

  sar_seq dut (.clk(clk), .rst_n(rst_n), .sar_en(sar_en), .src_sel(src_sel),
    .delay_trk(delay_trk), .res8(res8), .sw_go(sw_go), .tmr0_ovf(tmr0_ovf),
    .tmr2_ovf(tmr2_ovf), .tmr1_ovf(tmr1_ovf), .cnv_pin(cnv_pin), .cmp_hi(cmp_hi),
    .track(track), .busy(busy), .dac_code(dac_code), .step_stb(step_stb),
    .done(done), .result(result));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic cyc();
    @(negedge clk);
    divc++;
    sar_en = (divc % 4 == 0);
    {tmr1_ovf, tmr2_ovf, tmr0_ovf, sw_go} = go_next;
    go_next = 0;
    #1;
  endtask

  function automatic int exp_len(bit d, bit r8);
    return (r8 ? 12 : 14) + (d ? 3 : 0);
  endfunction

  function automatic logic [9:0] exp_stb(int k, bit d, bit r8);
    int j = k - (d ? 3 : 0);
    if (j >= 1 && j <= (r8 ? 8 : 10)) return 10'(1) << (10 - j);
    return '0;
  endfunction

  task automatic run_conv(input bit d, input bit r8, input logic [9:0] v,
                          input bit poke, input bit flip);
    int k = 0;
    bit seen = 0, ok_trk = 1, ok_stb = 1;
    logic [9:0] exp_res = r8 ? {2'b00, v[9:2]} : v;
    src_sel = 3'b000; delay_trk = d; res8 = r8; vin = v;
    go_next[0] = 1;
    cyc();
    for (int n = 0; n < 200 && !seen; n++) begin
      cyc();
      if (done) seen = 1;
      else if (busy) begin
        if (sar_en) begin
          k++;
          if (track != (k <= (d ? 3 : 0))) ok_trk = 0;
          if (step_stb != exp_stb(k, d, r8)) ok_stb = 0;
          if (poke && k == 5) go_next[0] = 1;
          if (flip && k == 2) begin delay_trk = ~d; res8 = ~r8; end
        end else if (step_stb != 0) ok_stb = 0;
      end
    end
    chk(seen, "R3 done seen", seen, 1);
    chk(k == exp_len(d, r8), flip ? "R10 length after option change" : "R5 conversion length",
        k, exp_len(d, r8));
    chk(ok_trk, "R6 track during conversion", ok_trk, 1);
    chk(ok_stb, "R8 step strobe order", ok_stb, 1);
    chk(result == exp_res, "R9 result", result, exp_res);
    chk(!busy, "R3 busy clear at done", busy, 0);
    cyc();
    chk(!done, "R3 done one cycle", done, 0);
    if (poke) begin
      for (int n = 0; n < 12; n++) cyc();
      chk(!busy, "R4 start while busy not queued", busy, 0);
    end
    chk(result == exp_res, "R9 result held", result, exp_res);
    delay_trk = 0; res8 = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 200 && !done; n++) cyc();
    cyc();
  endtask

  initial begin
    #720000;
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h51ab));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    chk(!busy && !done && result == 0 && step_stb == 0, "R3 reset state", busy, 0);
    chk(track, "R6 idle track after reset", track, 1);

    run_conv(0, 0, 10'd0, 0, 0);
    run_conv(0, 0, 10'h3ff, 0, 0);
    run_conv(1, 0, 10'h2a5, 0, 0);
    run_conv(0, 1, 10'h17b, 0, 0);
    run_conv(1, 1, 10'h3fe, 0, 0);
    run_conv(0, 0, 10'h155, 1, 0);
    run_conv(1, 0, 10'h0c3, 0, 1);
    for (int i = 0; i < 16; i++)
      run_conv($urandom_range(0, 1), $urandom_range(0, 1), 10'($urandom_range(0, 1023)), 0, 0);

    src_sel = 3'b001; vin = 10'd300;
    go_next = 4'b0101; cyc(); cyc(); cyc();
    chk(!busy, "R1 unselected sources ignored (sel 001)", busy, 0);
    go_next = 4'b0010; cyc(); cyc();
    chk(busy, "R1 timer0 starts (sel 001)", busy, 1);
    wait_done();
    src_sel = 3'b010;
    go_next = 4'b1011; cyc(); cyc(); cyc();
    chk(!busy, "R1 unselected sources ignored (sel 010)", busy, 0);
    go_next = 4'b0100; cyc(); cyc();
    chk(busy, "R1 timer2 starts (sel 010)", busy, 1);
    wait_done();
    src_sel = 3'b011;
    go_next = 4'b0111; cyc(); cyc(); cyc();
    chk(!busy, "R1 unselected sources ignored (sel 011)", busy, 0);
    go_next = 4'b1000; cyc(); cyc();
    chk(busy, "R1 timer1 starts (sel 011)", busy, 1);
    wait_done();

    src_sel = 3'b000; cnv_pin = 1; cyc(); cyc(); cyc(); cyc(); cyc();
    chk(!busy, "R1 pin ignored when software selected", busy, 0);
    cnv_pin = 0; delay_trk = 0; src_sel = 3'b110;
    cyc(); cyc(); cyc();
    chk(track, "R7 external idle pin low tracks", track, 1);
    cnv_pin = 1;
    cyc(); cyc();
    chk(!busy, "R2 no start before sync", busy, 0);
    cyc();
    chk(busy, "R2 start on third edge", busy, 1);
    chk(!track, "R7 external immediate converts", track, 0);
    wait_done();
    chk(!track, "R7 external idle pin high holds", track, 0);
    delay_trk = 1; #0.1;
    chk(track, "R7 external delayed mode idle tracks", track, 1);
    delay_trk = 0;
    for (int n = 0; n < 10; n++) cyc();
    chk(!busy, "R2 steady pin no restart", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule